// File: doc/BRIEF.md
# SPI FIFO status and interrupt unit

This unit sits between the register interface of an SPI master and its shift engine. It holds a transmit queue and a receive queue of 16 words each, up to 32 bits wide. Software fills the transmit queue and drains the receive queue through a single data register. The shift engine pops transmit words and pushes received words through simple strobes. The unit derives eight status flags from the fill levels and from two latched events. It then produces one interrupt line, gated by an enable register that uses the same bit layout as the status register.

Software reads the two fill counters from a test register. It can flush either queue, or both, by writing two soft-reset bits in that register. The transfer-complete event and the receive-overflow event are sticky, and software clears them by writing 1 to their status bits. A word that arrives while the receive queue is full is dropped and raises the overflow flag.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: The status register (address 2) reports bit 0 = transmit queue empty, bit 1 = transmit count >= 8, bit 2 = transmit count == 16, bit 3 = receive count >= 1, bit 4 = receive count >= 8, bit 5 = receive count == 16, bit 6 = receive overflow, bit 7 = transfer complete.
- R2: The enable register (address 1, bits 7:0) uses the same bit positions as the status register. `irq` is high exactly when some status bit and its enable bit are both 1.
- R3: A one-cycle `xfer_done` pulse sets status bit 7, and the bit stays set. Writing the status register with bit 7 = 1 clears it. Writing 0 to that bit has no effect.
- R4: A `rx_push` while the receive queue holds 16 words sets status bit 6, discards the word and leaves the count at 16. Bit 6 is sticky and is cleared by writing 1 to it.
- R5: Each queue holds 16 words of 32 bits in first-in first-out order. Transmit words appear on `tx_data` in the order they were written. Received words are returned by reads of address 0 in arrival order.
- R6: The test register (address 3) reads the transmit count at bits 4:0 and the receive count at bits 9:5. The same counts are driven on `tx_count` and `rx_count`.
- R7: Writing the test register with bit 10 set flushes the transmit queue. Bit 11 set flushes the receive queue. Both bits set flush both queues.
- R8: A write to address 0 while the transmit queue is full is ignored. The count stays 16 and the stored words are unchanged.
- R9: A read of address 0 while the receive queue is empty returns zero and leaves the count at 0.
- R10: After reset both counts are 0, the enable register is 0, the status register reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 enable, 2 status, 3 test |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address |
| tx_pop | input | 1 | Shift engine takes the head transmit word |
| tx_data | output | 32 | Head transmit word, zero when empty |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_data | input | 32 | Received word |
| xfer_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |
| tx_count | output | 5 | Transmit fill count |
| rx_count | output | 5 | Receive fill count |

## Verification
On every cycle the assertions check these properties: the fill counts stay in bounds, a write into a full transmit queue leaves it full, a push into a full receive queue latches the overflow flag without growing the count, the completion flag holds until it is cleared by a write of 1, an all-zero enable keeps `irq` low, and an empty-queue read returns zero. Only the bench scenarios can show the exact flag pattern at every fill level from 0 to 16, the word order through both queues, each soft-reset combination, and the interrupt result for all 256 enable values against two different status patterns.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ST_TX_EMPTY = 0;
  localparam int ST_TX_HALF  = 1;
  localparam int ST_TX_FULL  = 2;
  localparam int ST_RX_RDY   = 3;
  localparam int ST_RX_HALF  = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_RX_OVF   = 6;
  localparam int ST_DONE     = 7;
  localparam int ST_BITS     = 8;

  localparam int FLUSH_TX_BIT = 10;
  localparam int FLUSH_RX_BIT = 11;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_IEN  = 2'd1,
    REG_STAT = 2'd2,
    REG_TEST = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      tx_cnt,
  input  logic [CW-1:0]      rx_cnt,
  input  logic               ovf_evt,
  input  logic               done_evt,
  input  logic               ien_we,
  input  logic               stat_we,
  input  logic [ST_BITS-1:0] wdata,
  output logic [ST_BITS-1:0] status,
  output logic [ST_BITS-1:0] ien,
  output logic               irq
);
  logic [ST_BITS-1:0] ien_q, ien_d;
  logic ovf_q, ovf_d, done_q, done_d;

  always_comb begin
    ien_d  = ien_q;
    ovf_d  = ovf_q;
    done_d = done_q;
    if (ien_we) ien_d = wdata;
    if (stat_we && wdata[ST_RX_OVF]) ovf_d  = 1'b0;
    if (stat_we && wdata[ST_DONE])   done_d = 1'b0;
    if (ovf_evt)  ovf_d  = 1'b1;
    if (done_evt) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      ovf_q  <= ovf_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_TX_EMPTY] = (tx_cnt == '0);
    status[ST_TX_HALF]  = (tx_cnt >= CW'(HALF));
    status[ST_TX_FULL]  = (tx_cnt == CW'(DEPTH));
    status[ST_RX_RDY]   = (rx_cnt != '0);
    status[ST_RX_HALF]  = (rx_cnt >= CW'(HALF));
    status[ST_RX_FULL]  = (rx_cnt == CW'(DEPTH));
    status[ST_RX_OVF]   = ovf_q;
    status[ST_DONE]     = done_q;
  end

  assign ien = ien_q;
  assign irq = |(status & ien_q);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_data,
  output logic             tx_avail,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_data,
  input  logic             xfer_done,
  output logic             irq,
  output logic [CW-1:0]    tx_count,
  output logic [CW-1:0]    rx_count
);
  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  reg_sel_e           sel;
  logic               data_we, data_re, ien_we, stat_we, test_we;
  logic               flush_tx, flush_rx;
  logic [WIDTH-1:0]   tx_head, rx_head;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic [ST_BITS-1:0] status, ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign sel      = reg_sel_e'(reg_addr);
  assign data_we  = reg_wr && (sel == REG_DATA);
  assign data_re  = reg_rd && (sel == REG_DATA);
  assign ien_we   = reg_wr && (sel == REG_IEN);
  assign stat_we  = reg_wr && (sel == REG_STAT);
  assign test_we  = reg_wr && (sel == REG_TEST);
  assign flush_tx = test_we && reg_wdata[FLUSH_TX_BIT];
  assign flush_rx = test_we && reg_wdata[FLUSH_RX_BIT];

  spi_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_core_n), .flush(flush_tx),
    .push(data_we), .wdata(reg_wdata[WIDTH-1:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_count),
    .full(tx_full), .empty(tx_empty)
  );

  spi_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_core_n), .flush(flush_rx),
    .push(rx_push), .wdata(rx_data),
    .pop(data_re), .rdata(rx_head), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  spi_irq_status #(.DEPTH(DEPTH)) stat_i (
    .clk(clk), .rst_n(rst_core_n),
    .tx_cnt(tx_count), .rx_cnt(rx_count),
    .ovf_evt(rx_push && rx_full), .done_evt(xfer_done),
    .ien_we(ien_we), .stat_we(stat_we), .wdata(reg_wdata[ST_BITS-1:0]),
    .status(status), .ien(ien), .irq(irq)
  );

  assign tx_avail = !tx_empty;
  assign tx_data  = tx_empty ? '0 : tx_head;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_DATA: if (!rx_empty) reg_rdata[WIDTH-1:0] = rx_head;
      REG_IEN:  reg_rdata[ST_BITS-1:0] = ien;
      REG_STAT: reg_rdata[ST_BITS-1:0] = status;
      REG_TEST: begin
        reg_rdata[CW-1:0]    = tx_count;
        reg_rdata[2*CW-1:CW] = rx_count;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_irq_unit_chk.sv
module spi_fifo_irq_unit_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          irq,
  input logic [7:0]    status,
  input logic [7:0]    ien,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  p_txfull_drop_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_wr && reg_addr == 2'd0 && tx_count == CW'(DEPTH) && !tx_pop)
    |=> (tx_count == CW'(DEPTH)));

  p_ovf_latch_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_push && rx_count == CW'(DEPTH) && !(reg_rd && reg_addr == 2'd0)
     && !(reg_wr && reg_addr == 2'd3))
    |=> (status[6] && rx_count == CW'(DEPTH)));

  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (status[7] && !(reg_wr && reg_addr == 2'd2 && reg_wdata[7])) |=> status[7]);

  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ien == 8'h00) |-> !irq);

  p_empty_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_rd && reg_addr == 2'd0 && rx_count == '0) |-> (reg_rdata == 32'h0));
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_core_n(rst_core_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .tx_pop(tx_pop), .rx_push(rx_push), .irq(irq), .status(status),
  .ien(ien), .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/spi_fifo_irq_unit_tb_top.sv
module spi_fifo_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd, tx_pop, rx_push, xfer_done;
  logic [31:0] reg_wdata, reg_rdata, tx_data, rx_data;
  logic        tx_avail, irq;
  logic [4:0]  tx_count, rx_count;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_data(rx_data), .xfer_done(xfer_done),
    .irq(irq), .tx_count(tx_count), .rx_count(rx_count)
  );

  function automatic logic [7:0] exp_stat(int t, int r, bit ov, bit dn);
    return {dn, ov, r == 16, r >= 8, r >= 1, t == 16, t >= 8, t == 0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_data(output logic [31:0] d);
    reg_addr = 2'd0; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    rx_data = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic chk_state(input string req, input int t, input int r, input bit ov, input bit dn);
    logic [31:0] v;
    peek(2'd2, v);
    chk({req, " R1 status"}, v, {24'h0, exp_stat(t, r, ov, dn)});
    peek(2'd3, v);
    chk({req, " R6 test reg"}, v, 32'(r * 32 + t));
    chk({req, " R6 count ports"}, {22'h0, rx_count, tx_count}, 32'(r * 32 + t));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; tx_pop = 1'b0; rx_push = 1'b0; rx_data = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk_state("R10", 0, 0, 0, 0);
    peek(2'd1, v); chk("R10 enable", v, 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    chk("R10 tx_avail", {31'h0, tx_avail}, 32'h0);

    // R5/R8 transmit fill sweep, including two writes into a full queue
    for (int i = 0; i < 18; i++) begin
      wr(2'd0, 32'hA000_0000 + 32'(i));
      chk_state("R8 tx fill", (i + 1 > 16) ? 16 : i + 1, 0, 0, 0);
    end
    // R5 transmit drain in order; R8 dropped words never appear
    for (int i = 0; i < 16; i++) begin
      chk("R5 tx order", tx_data, 32'hA000_0000 + 32'(i));
      chk("R5 tx_avail", {31'h0, tx_avail}, 32'h1);
      pop_tx();
      chk_state("R1 tx drain", 15 - i, 0, 0, 0);
    end
    chk("R5 tx empty data", tx_data, 32'h0);

    // R4 receive fill sweep with one overflowing push
    for (int i = 0; i < 17; i++) begin
      push_rx(32'hB000_0000 + 32'(i));
      chk_state("R4 rx fill", 0, (i + 1 > 16) ? 16 : i + 1, i == 16, 0);
    end
    wr(2'd2, 32'h0000_0000);
    chk_state("R4 write0 keeps", 0, 16, 1, 0);
    wr(2'd2, 32'h0000_0040);
    chk_state("R4 w1c", 0, 16, 0, 0);
    // R5 receive order; overflow word discarded
    for (int i = 0; i < 16; i++) begin
      rd_data(v);
      chk("R5 rx order", v, 32'hB000_0000 + 32'(i));
      chk_state("R1 rx drain", 0, 15 - i, 0, 0);
    end
    rd_data(v);
    chk("R9 empty read", v, 32'h0);
    chk_state("R9 count", 0, 0, 0, 0);

    // R3 completion flag
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk_state("R3 set", 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk_state("R3 sticky", 0, 0, 0, 1);
    wr(2'd2, 32'h0000_007F);
    chk_state("R3 write0", 0, 0, 0, 1);
    wr(2'd2, 32'h0000_0080);
    chk_state("R3 w1c", 0, 0, 0, 0);

    // R2 interrupt sweep, status 0x01
    for (int e = 0; e < 256; e++) begin
      wr(2'd1, 32'(e));
      chk("R2 irq idle", {31'h0, irq}, {31'h0, |(8'(e) & 8'h01)});
    end
    peek(2'd1, v); chk("R2 enable readback", v, 32'hFF);

    // R2 interrupt sweep, status 0xFA
    for (int i = 0; i < 8; i++) wr(2'd0, 32'(i));
    for (int i = 0; i < 17; i++) push_rx(32'(i));
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk_state("R1 busy", 8, 16, 1, 1);
    for (int e = 0; e < 256; e++) begin
      wr(2'd1, 32'(e));
      chk("R2 irq busy", {31'h0, irq}, {31'h0, |(8'(e) & 8'hFA)});
    end

    // R7 soft reset combinations
    wr(2'd3, 32'h0000_0400);
    chk_state("R7 flush tx", 0, 16, 1, 1);
    wr(2'd3, 32'h0000_0800);
    chk_state("R7 flush rx", 0, 0, 1, 1);
    wr(2'd2, 32'h0000_00C0);
    chk_state("R7 clear", 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) wr(2'd0, 32'(i));
    for (int i = 0; i < 5; i++) push_rx(32'(i));
    chk_state("R7 refill", 3, 5, 0, 0);
    wr(2'd3, 32'h0000_0C00);
    chk_state("R7 flush both", 0, 0, 0, 0);
    wr(2'd0, 32'h1234_5678);
    chk("R7 after flush", tx_data, 32'h1234_5678);

    summary();
    $finish;
  end
endmodule